// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Emulator

This block stands in for a 16-bit wide asynchronous static RAM inside a synchronous design. A controller under test drives active-low select, output-enable, write-strobe and two per-byte lane enables, plus an address and write data. The emulator samples those pins on a fast internal clock, keeps the contents in a register array whose depth is set by a parameter, and tells the outside world, lane by lane, when it would drive the shared data bus and with what value.

The bus-drive decision follows the usual truth table of such parts: the emulator stays off the bus when deselected, when output-enable is inactive, when neither lane is enabled, or while a write is in progress. Writes are masked per byte lane and are committed when the write ends, using the address and data last seen while the lane was being written. A conflict output goes high in any cycle where the controller reports that it is driving the bus while the emulator also drives it, so that a controller's turnaround rules can be checked.

Top module: `sram_emu`

## Requirements
- R1: After synchronous reset is released, no lane is driven and `bus_clash` is low.
- R2: While the sampled `sel_n` is high, `drv_lane` is 0 regardless of the other pins.
- R3: While the sampled `oe_n` is high, `drv_lane` is 0.
- R4: While both sampled lane enables are high, `drv_lane` is 0.
- R5: While the sampled `sel_n` and `wr_n` are both low (a write), `drv_lane` is 0 even when `oe_n` is low.
- R6: A read is `sel_n` low, `wr_n` high and `oe_n` low; `drv_lane[0]` is set exactly when `lane_n[0]` is low and then `rd_data[7:0]` holds the low byte of the word at `addr`; `drv_lane[1]` likewise follows `lane_n[1]` with `rd_data[15:8]`. A lane whose enable is high is not driven and reads as zero.
- R7: A write with `lane_n[0]` low stores `wr_data[7:0]` into the low byte of the addressed word; `lane_n[1]` low stores `wr_data[15:8]` into the high byte; a lane whose enable stays high keeps its old byte.
- R8: A lane's write ends when any of `sel_n`, `wr_n` or that lane's enable is sampled high; the stored byte and address are those sampled in the last cycle the lane was still being written, and data changed afterwards is not stored. The new contents are readable by a read sampled on the same edge that samples the end of the write.
- R9: Raising `sel_n` and `wr_n` in the same cycle with `oe_n` low leaves `drv_lane` at 0.
- R10: `bus_clash` is high in exactly those cycles where the sampled `host_drv` is high and at least one lane is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low device select |
| oe_n | input | 1 | Active-low output enable |
| wr_n | input | 1 | Active-low write strobe |
| lane_n | input | LANES | Active-low byte-lane enables, bit 0 for bits 7:0 |
| addr | input | ADDR_W | Word address |
| wr_data | input | LANES*BYTE_W | Data the controller places on the bus |
| host_drv | input | 1 | High while the controller drives the bus |
| rd_data | output | LANES*BYTE_W | Data the emulator drives, zero on undriven lanes |
| drv_lane | output | LANES | Per-lane drive enable of the emulator |
| bus_clash | output | 1 | Both sides drive the bus in this cycle |

## Verification
Every pin is captured by one register, so each drive enable, read byte and conflict value is due right after the first rising edge that samples the stimulus, and a write's contents appear after the edge that samples its end. The bench applies pins on the falling edge, lets one rising edge pass, and compares a behavioural model (per-lane byte array and the previous pin set) against the outputs two time units later, on every clock. Write tests change data after the lane has closed and end writes through each of the three terminating pins to pin down which sample is stored.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;

    typedef struct packed {
        logic sel_n;
        logic oe_n;
        logic wr_n;
        logic host;
    } ctl_t;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_READ  = 2'd1,
        BUS_WRITE = 2'd2
    } bus_mode_e;

    localparam ctl_t CTL_IDLE = '{sel_n: 1'b1, oe_n: 1'b1, wr_n: 1'b1, host: 1'b0};

    function automatic bus_mode_e mode_of(ctl_t c);
        if (c.sel_n)      return BUS_IDLE;
        else if (!c.wr_n) return BUS_WRITE;
        else if (!c.oe_n) return BUS_READ;
        else              return BUS_IDLE;
    endfunction

    function automatic logic lane_writes(ctl_t c, logic lane_off);
        return (mode_of(c) == BUS_WRITE) && !lane_off;
    endfunction

    function automatic logic lane_reads(ctl_t c, logic lane_off);
        return (mode_of(c) == BUS_READ) && !lane_off;
    endfunction

endpackage

// File: rtl/sram_emu_sampler.sv
module sram_emu_sampler
    import sram_emu_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int BYTE_W = 8,
    localparam int DATA_W = LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl_in,
    input  logic [LANES-1:0]  lane_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output ctl_t              ctl_q,
    output logic [LANES-1:0]  lane_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q,
    output logic [LANES-1:0]  commit
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= CTL_IDLE;
            lane_q <= '1;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            ctl_q  <= ctl_in;
            lane_q <= lane_in;
            addr_q <= addr_in;
            data_q <= data_in;
        end
    end

    // A lane commits on the edge where its write was active in the held
    // sample and is no longer active in the incoming pins.
    for (genvar g = 0; g < LANES; g++) begin : g_end
        always_comb begin
            commit[g] = !rst
                     && lane_writes(ctl_q, lane_q[g])
                     && !lane_writes(ctl_in, lane_in[g]);
        end
    end

    // R8: a commit is only ever preceded by an active write sample
    a_r8_commit_after_write: assert property (@(posedge clk) disable iff (rst)
        (|commit) |-> (mode_of(ctl_q) == BUS_WRITE));

endmodule

// File: rtl/sram_emu_store.sv
module sram_emu_store #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int BYTE_W = 8,
    localparam int DATA_W = LANES * BYTE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LANES-1:0]  commit,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_word,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (commit[g]) begin
                cells[wr_addr] <= wr_word[g*BYTE_W +: BYTE_W];
            end
        end

        assign rd_word[g*BYTE_W +: BYTE_W] = cells[rd_addr];

        // R7: a committed byte lands in its own lane at the held address
        a_r7_lane_stored: assert property (@(posedge clk) disable iff (rst)
            commit[g] |=> (cells[$past(wr_addr)] == $past(wr_word[g*BYTE_W +: BYTE_W])));
    end

endmodule

// File: rtl/sram_emu_drive.sv
module sram_emu_drive
    import sram_emu_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int BYTE_W = 8,
    localparam int DATA_W = LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl_q,
    input  logic [LANES-1:0]  lane_q,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_data,
    output logic [LANES-1:0]  drv_lane,
    output logic              bus_clash
);

    for (genvar g = 0; g < LANES; g++) begin : g_drv
        always_comb begin
            drv_lane[g] = lane_reads(ctl_q, lane_q[g]);
            rd_data[g*BYTE_W +: BYTE_W] = drv_lane[g] ? rd_word[g*BYTE_W +: BYTE_W]
                                                      : '0;
        end
    end

    assign bus_clash = ctl_q.host && (drv_lane != '0);

    a_r2_desel_quiet: assert property (@(posedge clk) disable iff (rst)
        ctl_q.sel_n |-> (drv_lane == '0));

    a_r3_oe_quiet: assert property (@(posedge clk) disable iff (rst)
        ctl_q.oe_n |-> (drv_lane == '0));

    a_r4_lanes_off_quiet: assert property (@(posedge clk) disable iff (rst)
        (lane_q == '1) |-> (drv_lane == '0));

    a_r5_write_quiet: assert property (@(posedge clk) disable iff (rst)
        (!ctl_q.sel_n && !ctl_q.wr_n) |-> (drv_lane == '0));

    a_r6_lane_follows_enable: assert property (@(posedge clk) disable iff (rst)
        ((drv_lane & lane_q) == '0));

endmodule

// File: rtl/sram_emu.sv
module sram_emu
    import sram_emu_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int BYTE_W = 8,
    localparam int DATA_W = LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              oe_n,
    input  logic              wr_n,
    input  logic [LANES-1:0]  lane_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              host_drv,
    output logic [DATA_W-1:0] rd_data,
    output logic [LANES-1:0]  drv_lane,
    output logic              bus_clash
);

    ctl_t              ctl_in;
    ctl_t              ctl_q;
    logic [LANES-1:0]  lane_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [LANES-1:0]  commit;
    logic [DATA_W-1:0] rd_word;

    always_comb begin
        ctl_in.sel_n = sel_n;
        ctl_in.oe_n  = oe_n;
        ctl_in.wr_n  = wr_n;
        ctl_in.host  = host_drv;
    end

    sram_emu_sampler #(.ADDR_W(ADDR_W), .LANES(LANES), .BYTE_W(BYTE_W)) u_smp (
        .clk     (clk),
        .rst     (rst),
        .ctl_in  (ctl_in),
        .lane_in (lane_n),
        .addr_in (addr),
        .data_in (wr_data),
        .ctl_q   (ctl_q),
        .lane_q  (lane_q),
        .addr_q  (addr_q),
        .data_q  (data_q),
        .commit  (commit)
    );

    sram_emu_store #(.ADDR_W(ADDR_W), .LANES(LANES), .BYTE_W(BYTE_W)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .commit  (commit),
        .wr_addr (addr_q),
        .wr_word (data_q),
        .rd_addr (addr_q),
        .rd_word (rd_word)
    );

    sram_emu_drive #(.LANES(LANES), .BYTE_W(BYTE_W)) u_drv (
        .clk       (clk),
        .rst       (rst),
        .ctl_q     (ctl_q),
        .lane_q    (lane_q),
        .rd_word   (rd_word),
        .rd_data   (rd_data),
        .drv_lane  (drv_lane),
        .bus_clash (bus_clash)
    );

    // R9: a write closed by select rising leaves the bus undriven
    a_r9_close_quiet: assert property (@(posedge clk) disable iff (rst)
        ($past(!ctl_q.sel_n && !ctl_q.wr_n) && ctl_q.sel_n) |-> (drv_lane == '0));

    // R1: the cycle after reset nothing is driven
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (drv_lane == '0 && !bus_clash));

endmodule

// File: tb/sim_sram_emu.sv
module sim_sram_emu;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_n = 1'b1, oe_n = 1'b1, wr_n = 1'b1, host_drv = 1'b0;
    logic [1:0]  lane_n = 2'b11;
    logic [7:0]  addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [1:0]  drv_lane;
    logic        bus_clash;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // behavioural reference: byte array per lane plus last applied pins
    logic [7:0] ref_mem [256][2];
    bit         ref_known [256][2];
    logic       p_sel = 1, p_wr = 1;
    logic [1:0] p_lane = 2'b11;
    logic [7:0] p_addr = '0;
    logic [15:0] p_data = '0;

    sram_emu u0 (
        .clk(clk), .rst(rst), .sel_n(sel_n), .oe_n(oe_n), .wr_n(wr_n),
        .lane_n(lane_n), .addr(addr), .wr_data(wr_data), .host_drv(host_drv),
        .rd_data(rd_data), .drv_lane(drv_lane), .bus_clash(bus_clash)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag, logic s, logic o, logic w, logic [1:0] l,
                        logic [7:0] a, logic [15:0] d, logic h);
        logic [1:0] e_drv;
        @(negedge clk);
        sel_n = s; oe_n = o; wr_n = w; lane_n = l; addr = a; wr_data = d; host_drv = h;
        @(posedge clk);
        #2;
        for (int i = 0; i < 2; i++) begin
            bit was_w = !p_sel && !p_wr && !p_lane[i];
            bit is_w  = !s && !w && !l[i];
            if (was_w && !is_w) begin
                ref_mem[p_addr][i]   = p_data[i*8 +: 8];
                ref_known[p_addr][i] = 1;
            end
        end
        p_sel = s; p_wr = w; p_lane = l; p_addr = a; p_data = d;
        for (int i = 0; i < 2; i++) e_drv[i] = !s && !o && w && !l[i];
        check(tag, "drv_lane", {14'd0, drv_lane}, {14'd0, e_drv});
        check(tag, "bus_clash", {15'd0, bus_clash}, {15'd0, h && (e_drv != 0)});
        for (int i = 0; i < 2; i++) begin
            if (!e_drv[i])
                check(tag, "idle lane data", {8'd0, rd_data[i*8 +: 8]}, 16'd0);
            else if (ref_known[a][i])
                check(tag, "read byte", {8'd0, rd_data[i*8 +: 8]}, {8'd0, ref_mem[a][i]});
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #2;
        check("R1", "drv_lane after reset", {14'd0, drv_lane}, 16'd0);
        check("R1", "bus_clash after reset", {15'd0, bus_clash}, 16'd0);

        // R8: full-word write, data changes while active; last sample stored
        step("R8", 0, 1, 0, 2'b00, 8'h05, 16'hAAAA, 0);
        step("R8", 0, 1, 0, 2'b00, 8'h05, 16'h1234, 0);
        step("R8", 0, 0, 1, 2'b00, 8'h05, 16'h7777, 0); // read on the closing edge
        step("R6", 0, 0, 1, 2'b00, 8'h05, 16'h0000, 0);

        // R7: lane-masked writes keep the other byte
        step("R7", 0, 1, 0, 2'b10, 8'h05, 16'hFFCD, 0);
        step("R7", 1, 1, 1, 2'b11, 8'h05, 16'h0000, 0);
        step("R7", 0, 0, 1, 2'b00, 8'h05, 16'h0000, 0);
        step("R7", 0, 1, 0, 2'b01, 8'h05, 16'hEF11, 0);
        step("R7", 0, 1, 1, 2'b01, 8'h05, 16'h0000, 0);
        step("R7", 0, 0, 1, 2'b00, 8'h05, 16'h0000, 0);

        // R6: single-lane reads
        step("R6", 0, 0, 1, 2'b01, 8'h05, 16'h0000, 0);
        step("R6", 0, 0, 1, 2'b10, 8'h05, 16'h0000, 0);

        // R2..R5: quiet conditions with everything else asking to read
        step("R2", 1, 0, 1, 2'b00, 8'h05, 16'h0000, 0);
        step("R3", 0, 1, 1, 2'b00, 8'h05, 16'h0000, 0);
        step("R4", 0, 0, 1, 2'b11, 8'h05, 16'h0000, 0);
        step("R5", 0, 0, 0, 2'b00, 8'h09, 16'h0F0F, 0);
        step("R5", 0, 0, 0, 2'b00, 8'h09, 16'h2468, 0);

        // R9: select and strobe rise together with oe low
        step("R9", 1, 0, 1, 2'b00, 8'h09, 16'h9999, 0);
        step("R9", 1, 0, 1, 2'b00, 8'h09, 16'h9999, 0);
        step("R8", 0, 0, 1, 2'b00, 8'h09, 16'h0000, 0);

        // R8: write closed by lanes rising; later data with lanes off not stored
        step("R8", 0, 1, 0, 2'b00, 8'h07, 16'h5555, 0);
        step("R8", 0, 1, 0, 2'b11, 8'h07, 16'h9999, 0);
        step("R8", 0, 1, 0, 2'b11, 8'h07, 16'h8888, 0);
        step("R8", 0, 0, 1, 2'b00, 8'h07, 16'h0000, 0);
        // closed by select: address is the last active sample
        step("R8", 0, 1, 0, 2'b00, 8'h20, 16'hC3C3, 0);
        step("R8", 1, 1, 0, 2'b00, 8'h21, 16'h3C3C, 0);
        step("R8", 0, 0, 1, 2'b00, 8'h20, 16'h0000, 0);
        step("R8", 0, 0, 1, 2'b00, 8'h07, 16'h0000, 0);

        // R10: conflict only when both drive
        step("R10", 0, 0, 1, 2'b00, 8'h07, 16'h0000, 1);
        step("R10", 0, 0, 1, 2'b10, 8'h07, 16'h0000, 1);
        step("R10", 0, 1, 0, 2'b00, 8'h30, 16'h1111, 1);
        step("R10", 1, 1, 1, 2'b11, 8'h30, 16'h0000, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule